// File: doc/BRIEF.md
# Dual-Converter Sampling Readout Controller

This block runs on the host side of a two-channel SAR converter that samples both of its inputs at the same instant. For each request it drives the conversion-start line low for a fixed number of system clocks. It then waits for the converter's busy line to rise and to fall. After that it runs a serial clock and shifts in the two results. The block also drives the channel-pair select line. It takes that level when the request is accepted and holds it through the conversion, so the level is stable when the converter latches it on the rising edge of busy.

Each request picks one of two readout modes. In split mode the two data lines are read side by side and each one delivers the result of its own converter. In chained mode only data line A is read, for twice the word length inside a single chip-select window: the first word is converter A's result and the second is converter B's. Every timing limit is set as a count of system clock cycles. If busy has not fallen within a timeout window, the controller reports an error and returns to idle.

Top module: `ssadc_rd`

## Requirements
- R1: While reset is held, and after it is released, chip-select, conversion-start and the serial clock are high, and the valid and error flags are low.
- R2: An accepted request drives the conversion-start line low for exactly CNV_LOW_CYC system cycles. Chip-select stays high for that whole time.
- R3: Chip-select goes low only after busy has been seen high, and it is already low when busy falls. The MSB present at that moment is taken as the first bit.
- R4: The serial clock idles high while chip-select is high. Each low phase lasts SCLK_HALF system cycles, and so does each high phase between two falling edges. Input data is sampled when the serial clock rises.
- R5: In split mode (chain_i = 0 at acceptance) WORD_W falling serial-clock edges are generated. word_a_o holds the WORD_W bits from dout_a_i and word_b_o holds those from dout_b_i, each received MSB first.
- R6: In chained mode (chain_i = 1 at acceptance) 2*WORD_W falling serial-clock edges are generated, and only dout_a_i is used. The first WORD_W bits go to word_a_o and the next WORD_W bits go to word_b_o, both MSB first.
- R7: addr_o takes the value of pair_sel_i when a request is accepted. It does not change until the controller is idle again, so it is stable at the rising edge of busy.
- R8: valid_o is high for exactly one cycle per completed read. The word outputs keep their values until the next completed read.
- R9: After chip-select rises, at least QUIET_CYC system cycles pass before the conversion-start line falls again. A request held during that time waits.
- R10: If busy has not fallen within TMO_CYC cycles of the conversion-start falling edge, timeout_err_o is set in exactly that cycle, chip-select is high, valid is not raised and the controller goes back toward idle. The next accepted request clears the flag.
- R11: start_i is ignored while a conversion or a read is in progress, so one transaction gives exactly one conversion-start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, accepted when idle |
| chain_i | input | 1 | Readout mode for the request: 0 split, 1 chained |
| pair_sel_i | input | 1 | Channel-pair select for the request |
| busy_i | input | 1 | Converter busy line |
| dout_a_i | input | 1 | Serial data line A |
| dout_b_i | input | 1 | Serial data line B |
| cnv_n_o | output | 1 | Conversion start, active low |
| cs_n_o | output | 1 | Chip-select, active low |
| sclk_o | output | 1 | Serial clock |
| addr_o | output | 1 | Channel-pair select to the converter |
| word_a_o | output | WORD_W | Result of converter A |
| word_b_o | output | WORD_W | Result of converter B |
| valid_o | output | 1 | One-cycle strobe: new words are present |
| timeout_err_o | output | 1 | Busy did not fall in time |

## Verification
The assertions assume that busy_i, dout_a_i and dout_b_i are already synchronous to clk. They also assume busy rises some cycles after the start pulse and that the converter changes its data only on falling serial-clock edges. The bench's converter model drives all of these lines on the falling system-clock edge and keeps data on the line for a full serial half period. It raises busy three cycles after the start falls, and it can be told never to raise busy or never to lower it, which exercises the timeout path. Requests are held high until they are accepted, so the quiet-time wait is exercised on every back-to-back transaction.

// File: rtl/ssadc_pkg.sv
`timescale 1ns/1ps
package ssadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNV,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_SHIFT,
    ST_QUIET
  } ssadc_state_e;
endpackage

// File: rtl/ssadc_sclk_gen.sv
`timescale 1ns/1ps
module ssadc_sclk_gen #(
  parameter int SCLK_HALF = 5,
  parameter int SEQ_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEQ_W-1:0] n_per,
  output logic             sclk_o,
  output logic             rise_now_o,
  output logic [SEQ_W-1:0] per_o,
  output logic             done_o
);
  localparam int PH_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  logic [PH_W-1:0] ph_q;
  logic            ph_end;

  assign ph_end     = (ph_q == PH_W'(SCLK_HALF - 1));
  assign rise_now_o = run && !done_o && ph_end && !sclk_o;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sclk_o <= 1'b1;
      ph_q   <= '0;
      per_o  <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      if (ph_end) begin
        ph_q <= '0;
        if (sclk_o) begin
          if (per_o == n_per) done_o <= 1'b1;
          else                sclk_o <= 1'b0;
        end else begin
          sclk_o <= 1'b1;
          per_o  <= per_o + SEQ_W'(1);
        end
      end else begin
        ph_q <= ph_q + PH_W'(1);
      end
    end
  end

  // R4: the clock is parked high once the period count is reached
  a_r4_done_high: assert property (@(posedge clk) disable iff (rst)
    done_o |-> sclk_o);
  // R5/R6: never more periods than requested
  a_r6_per_limit: assert property (@(posedge clk) disable iff (rst)
    run |-> (per_o <= n_per));
endmodule

// File: rtl/ssadc_capture.sv
`timescale 1ns/1ps
module ssadc_capture #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              chain,
  input  logic              fin,
  input  logic              din_a,
  input  logic              din_b,
  output logic [WORD_W-1:0] word_a_o,
  output logic [WORD_W-1:0] word_b_o,
  output logic              valid_o
);
  localparam int LONG_W = 2 * WORD_W;

  logic [LONG_W-1:0] sh_a_q;
  logic [WORD_W-1:0] sh_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_a_q <= '0;
      sh_b_q <= '0;
    end else if (cap) begin
      sh_a_q <= {sh_a_q[LONG_W-2:0], din_a};
      sh_b_q <= {sh_b_q[WORD_W-2:0], din_b};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_a_o <= '0;
      word_b_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= fin;
      if (fin) begin
        word_a_o <= chain ? sh_a_q[LONG_W-1:WORD_W] : sh_a_q[WORD_W-1:0];
        word_b_o <= chain ? sh_a_q[WORD_W-1:0]      : sh_b_q;
      end
    end
  end

  // R8: strobe lasts one cycle
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R8: words only move with the strobe
  a_r8_words_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(word_a_o) && $stable(word_b_o)) || $past(rst));
endmodule

// File: rtl/ssadc_rd.sv
`timescale 1ns/1ps
module ssadc_rd
  import ssadc_pkg::*;
#(
  parameter int WORD_W      = 12,
  parameter int SCLK_HALF   = 5,
  parameter int CNV_LOW_CYC = 2,
  parameter int QUIET_CYC   = 10,
  parameter int TMO_CYC     = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              chain_i,
  input  logic              pair_sel_i,
  input  logic              busy_i,
  input  logic              dout_a_i,
  input  logic              dout_b_i,
  output logic              cnv_n_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              addr_o,
  output logic [WORD_W-1:0] word_a_o,
  output logic [WORD_W-1:0] word_b_o,
  output logic              valid_o,
  output logic              timeout_err_o
);
  localparam int SEQ_W    = $clog2(2 * WORD_W + 1);
  localparam int HOLD_MAX = (CNV_LOW_CYC > QUIET_CYC) ? CNV_LOW_CYC : QUIET_CYC;
  localparam int HOLD_W   = $clog2(HOLD_MAX + 1);
  localparam int TMO_W    = $clog2(TMO_CYC + 1);
  localparam logic [SEQ_W-1:0] PER_ONE = SEQ_W'(WORD_W);
  localparam logic [SEQ_W-1:0] PER_TWO = SEQ_W'(2 * WORD_W);

  ssadc_state_e      state_q;
  logic [HOLD_W-1:0] cnt_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              cs_n_q, cnv_n_q, addr_q, mode_q, err_q;

  logic [SEQ_W-1:0]  n_per, per_cnt;
  logic              rise_now, sclk_done, cap_first, cap_en, fin, timed_out;

  assign n_per     = mode_q ? PER_TWO : PER_ONE;
  assign timed_out = (tmo_q == TMO_W'(TMO_CYC - 1));
  assign cap_first = (state_q == ST_WAIT_LO) && !busy_i;
  assign cap_en    = cap_first || (rise_now && (per_cnt < n_per - SEQ_W'(1)));
  assign fin       = (state_q == ST_SHIFT) && sclk_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tmo_q   <= '0;
      cs_n_q  <= 1'b1;
      cnv_n_q <= 1'b1;
      addr_q  <= 1'b0;
      mode_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          addr_q  <= pair_sel_i;
          mode_q  <= chain_i;
          err_q   <= 1'b0;
          cnv_n_q <= 1'b0;
          cnt_q   <= '0;
          tmo_q   <= '0;
          state_q <= ST_CNV;
        end
        ST_CNV: begin
          tmo_q <= tmo_q + TMO_W'(1);
          if (cnt_q == HOLD_W'(CNV_LOW_CYC - 1)) begin
            cnv_n_q <= 1'b1;
            state_q <= ST_WAIT_HI;
          end else begin
            cnt_q <= cnt_q + HOLD_W'(1);
          end
        end
        ST_WAIT_HI, ST_WAIT_LO: begin
          tmo_q <= tmo_q + TMO_W'(1);
          if (state_q == ST_WAIT_HI && busy_i) begin
            cs_n_q  <= 1'b0;
            state_q <= ST_WAIT_LO;
          end else if (state_q == ST_WAIT_LO && !busy_i) begin
            state_q <= ST_SHIFT;
          end else if (timed_out) begin
            err_q   <= 1'b1;
            cs_n_q  <= 1'b1;
            cnt_q   <= '0;
            state_q <= ST_QUIET;
          end
        end
        ST_SHIFT: if (sclk_done) begin
          cs_n_q  <= 1'b1;
          cnt_q   <= '0;
          state_q <= ST_QUIET;
        end
        ST_QUIET: begin
          if (cnt_q == HOLD_W'(QUIET_CYC - 1)) state_q <= ST_IDLE;
          else                                 cnt_q   <= cnt_q + HOLD_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  ssadc_sclk_gen #(.SCLK_HALF(SCLK_HALF), .SEQ_W(SEQ_W)) u_sclk (
    .clk(clk), .rst(rst), .run(state_q == ST_SHIFT), .n_per(n_per),
    .sclk_o(sclk_o), .rise_now_o(rise_now), .per_o(per_cnt), .done_o(sclk_done)
  );

  ssadc_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst(rst), .cap(cap_en), .chain(mode_q), .fin(fin),
    .din_a(dout_a_i), .din_b(dout_b_i),
    .word_a_o(word_a_o), .word_b_o(word_b_o), .valid_o(valid_o)
  );

  assign cnv_n_o       = cnv_n_q;
  assign cs_n_o        = cs_n_q;
  assign addr_o        = addr_q;
  assign timeout_err_o = err_q;

  // cycles since chip-select was last low, saturating, for the quiet check
  logic [HOLD_W-1:0] since_cs_q;
  always_ff @(posedge clk) begin
    if (rst)                                   since_cs_q <= HOLD_W'(QUIET_CYC);
    else if (!cs_n_q)                          since_cs_q <= '0;
    else if (since_cs_q < HOLD_W'(QUIET_CYC))  since_cs_q <= since_cs_q + HOLD_W'(1);
  end

  // R2: start pulse never overlaps a read window
  a_r2_cnv_cs_high: assert property (@(posedge clk) disable iff (rst)
    !cnv_n_q |-> cs_n_q);
  // R3: chip-select falls only after busy has been seen high
  a_r3_cs_after_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_q) |-> $past(busy_i));
  // R4: serial clock parked high outside the read window
  a_r4_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |-> sclk_o);
  // R7: pair select frozen while a transaction runs
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(addr_q));
  // R9: quiet time before the next start
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(cnv_n_q) |-> (since_cs_q >= HOLD_W'(QUIET_CYC)));
  // R10: timeout leaves with chip-select high and no strobe
  a_r10_err_exit: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> (cs_n_q && !valid_o));
endmodule

// File: tb/ssadc_rd_tb.sv
`timescale 1ns/1ps
module ssadc_rd_tb;
  localparam int W     = 12;
  localparam int HALF  = 5;
  localparam int CNVL  = 2;
  localparam int QUIET = 10;
  localparam int TMO   = 300;
  localparam int BUSY  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, chain_i = 1'b0, pair_sel_i = 1'b0;
  logic busy_i = 1'b0, dout_a_i = 1'b0, dout_b_i = 1'b0;
  logic cnv_n_o, cs_n_o, sclk_o, addr_o, valid_o, err_o;
  logic [W-1:0] word_a_o, word_b_o;

  always #2.5 clk = ~clk;

  ssadc_rd #(.WORD_W(W), .SCLK_HALF(HALF), .CNV_LOW_CYC(CNVL),
             .QUIET_CYC(QUIET), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .chain_i(chain_i),
    .pair_sel_i(pair_sel_i), .busy_i(busy_i), .dout_a_i(dout_a_i),
    .dout_b_i(dout_b_i), .cnv_n_o(cnv_n_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .addr_o(addr_o), .word_a_o(word_a_o), .word_b_o(word_b_o),
    .valid_o(valid_o), .timeout_err_o(err_o)
  );

  int checks = 0, fails = 0, cyc_g = 0;
  bit done_flag = 0;
  always @(posedge clk) cyc_g <= cyc_g + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int k, input bit side, input bit ch);
    logic [W-1:0] v;
    case (k)
      0: v = '1;
      1: v = {(W/2){2'b10}};
      2: v = {1'b1, {(W-1){1'b0}}};
      default: v = W'(k * 1187 + 59);
    endcase
    if (side) v = ~v ^ W'(k * 13);
    if (ch) v = {v[0], v[W-1:1]} ^ W'(5);
    return v;
  endfunction

  // converter model: all lines driven on the falling system clock edge
  int hang = 0, m_cnt = 0, kload = 0;
  bit m_on = 0, cs_early = 0;
  logic ch_cur = 0, ch_next = 0, cnv_prev = 1, sclk_prev = 1;
  logic [2*W-1:0] sr_a = '0, sr_b = '0;
  always @(negedge clk) begin
    if (rst) begin
      m_on = 0; cnv_prev = 1; sclk_prev = 1; busy_i = 0;
    end else begin
      if (cnv_prev && !cnv_n_o) begin
        m_on = 1; m_cnt = 0;
      end else if (m_on) begin
        m_cnt++;
        if (m_cnt == 3 && hang != 1) begin busy_i = 1; ch_next = addr_o; end
        if (hang == 0 && m_cnt == 3 + BUSY) begin
          busy_i = 0;
          cs_early = !cs_n_o;
          sr_a = {pat(kload, 0, ch_cur), pat(kload, 1, ch_cur)};
          sr_b = {pat(kload, 1, ch_cur), pat(kload, 0, ch_cur)};
          kload++;
          ch_cur = ch_next;
          m_on = 0;
        end
        if (hang == 2 && m_cnt == 3 + TMO + 30) begin busy_i = 0; ch_cur = ch_next; m_on = 0; end
        if (hang == 1 && m_cnt > TMO + 30) m_on = 0;
      end
      if (sclk_prev && !sclk_o && !cs_n_o) begin
        sr_a = {sr_a[2*W-2:0], 1'b0};
        sr_b = {sr_b[2*W-2:0], 1'b0};
      end
      dout_a_i = sr_a[2*W-1];
      dout_b_i = sr_b[2*W-1];
      cnv_prev = cnv_n_o;
      sclk_prev = sclk_o;
    end
  end

  logic [W-1:0] last_a = '0, last_b = '0;
  int last_cs_rise = 0, exp_k = 0;
  bit have_rise = 0;
  logic exp_ch = 0;

  task automatic run_txn(input bit chain, input bit sel, input int hng, input bit poke);
    int lo_run = 0, hi_run = 0, falls = 0, cnv_low = 1, cnv_falls = 1;
    int addr_bad = 0, ph_bad = 0, t_fall, t_err = 0;
    bit got = 0, seen_rise = 0, prev_cnv = 0, prev_sclk = 1, got_valid = 0, got_err = 0;
    logic [W-1:0] ca = '0, cb = '0, ea, eb;
    chk(word_a_o === last_a && word_b_o === last_b, "R8 words held", int'(word_a_o), int'(last_a));
    hang = hng;
    @(negedge clk);
    start_i = 1; chain_i = chain; pair_sel_i = sel;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      if (!cnv_n_o) got = 1;
    end
    t_fall = cyc_g;
    start_i = 0; chain_i = ~chain; pair_sel_i = ~sel;
    chk(got, "R2 start accepted", int'(got), 1);
    chk(err_o == 1'b0, "R10 error cleared by new request", int'(err_o), 0);
    if (have_rise) chk(t_fall - last_cs_rise >= QUIET, "R9 quiet gap", t_fall - last_cs_rise, QUIET);
    for (int i = 0; i < 3000 && !(got_valid || got_err); i++) begin
      start_i = poke && (i == 80);
      @(negedge clk);
      if (!cnv_n_o) begin
        cnv_low++;
        if (prev_cnv) cnv_falls++;
      end
      if (addr_o !== sel) addr_bad++;
      if (!sclk_o) begin
        if (prev_sclk) begin
          falls++;
          if (seen_rise && hi_run != HALF) ph_bad++;
          lo_run = 1;
        end else lo_run++;
      end else begin
        if (!prev_sclk) begin
          if (lo_run != HALF) ph_bad++;
          seen_rise = 1; hi_run = 1;
        end else hi_run++;
      end
      if (!sclk_o && cs_n_o) ph_bad++;
      if (valid_o) begin got_valid = 1; ca = word_a_o; cb = word_b_o; end
      if (err_o) begin got_err = 1; t_err = cyc_g; end
      prev_cnv = cnv_n_o;
      prev_sclk = sclk_o;
    end
    start_i = 0;
    last_cs_rise = cyc_g; have_rise = 1;
    chk(cs_n_o == 1'b1, "R10/R5 chip-select high at end", int'(cs_n_o), 1);
    chk(cnv_low == CNVL, "R2 start pulse width", cnv_low, CNVL);
    chk(cnv_falls == 1, "R11 single start pulse", cnv_falls, 1);
    chk(addr_bad == 0, "R7 pair select held", addr_bad, 0);
    if (hng != 0) begin
      chk(got_err && !got_valid, "R10 timeout flagged without strobe", int'(got_valid), 0);
      chk(t_err - t_fall == TMO, "R10 timeout cycle", t_err - t_fall, TMO);
      chk(falls == 0, "R10 no serial clock", falls, 0);
      if (hng == 2) exp_ch = sel;
    end else begin
      ea = pat(exp_k, 0, exp_ch);
      eb = pat(exp_k, 1, exp_ch);
      chk(got_valid && !got_err, "R5 read completed", int'(got_valid), 1);
      chk(cs_early, "R3 chip-select low before busy falls", int'(cs_early), 1);
      chk(ph_bad == 0, "R4 serial clock phases", ph_bad, 0);
      chk(falls == (chain ? 2*W : W), chain ? "R6 clock count" : "R5 clock count",
          falls, chain ? 2*W : W);
      chk(ca === ea, chain ? "R6 word A" : "R5 word A", int'(ca), int'(ea));
      chk(cb === eb, chain ? "R6 word B" : "R5 word B", int'(cb), int'(eb));
      last_a = ca; last_b = cb;
      exp_k++;
      exp_ch = sel;
    end
    @(negedge clk);
    chk(valid_o == 1'b0, "R8 strobe one cycle", int'(valid_o), 0);
  endtask

  initial begin
    start_i = 1;
    repeat (4) @(negedge clk);
    chk(cs_n_o && cnv_n_o && sclk_o, "R1 lines high in reset", int'({cs_n_o, cnv_n_o, sclk_o}), 7);
    chk(!valid_o && !err_o, "R1 flags low in reset", int'({valid_o, err_o}), 0);
    start_i = 0;
    rst = 0;
    repeat (3) @(negedge clk);
    chk(cs_n_o && cnv_n_o && sclk_o, "R1 lines high after reset", int'({cs_n_o, cnv_n_o, sclk_o}), 7);
    chk(!valid_o && !err_o, "R1 flags low after reset", int'({valid_o, err_o}), 0);
    for (int d = 0; d < 4; d++)
      for (int m = 0; m < 2; m++)
        for (int s = 0; s < 2; s++)
          run_txn(m[0], s[0] ^ d[0], 0, 0);
    run_txn(1'b1, 1'b1, 0, 1);
    run_txn(1'b0, 1'b0, 0, 1);
    run_txn(1'b0, 1'b1, 1, 0);
    repeat (60) @(negedge clk);
    run_txn(1'b1, 1'b0, 0, 0);
    run_txn(1'b0, 1'b1, 2, 0);
    repeat (60) @(negedge clk);
    run_txn(1'b0, 1'b0, 0, 0);
    run_txn(1'b1, 1'b1, 0, 0);
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_g, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule